// File: doc/BRIEF.md
# Framed Packet Ones-Count Receiver

This block watches a serial bit stream, one bit per clock, and picks out fixed-length packets. A packet is opened by a pair of consecutive ones that comes right after a zero, and those two ones are the first two bits of the packet. Once a packet is open, the receiver takes in the remaining bits without looking for a new opening. When the last bit arrives, the block judges the whole packet by how many ones it holds.

The single output bit is high for one cycle, in the same cycle as the final packet bit, when the packet holds exactly the target number of ones. It is low in every other cycle. Packet length, opening run length and target count are parameters. The defaults are a five-bit packet, a two-one opening and a target of three ones.

Top module: `pktrx_ones_frame`

## Requirements
- R1: A packet opens in the cycle where the second of two consecutive ones arrives, provided the bit just before those two ones was a zero. Directly after reset, the bit before the first sampled bit counts as a zero.
- R2: A packet is exactly `PKT_BITS` (default 5) bits long, counting the two opening ones as its first two bits.
- R3: `dout` is 1 in the cycle of the last packet bit if and only if the packet's bits hold exactly `HIT_ONES` (default 3) ones. `dout` is derived from the current `din` and the stored state, so it appears without a register delay.
- R4: While a packet is open, two ones that follow a zero do not open a new packet. Such a pair starts nothing until the current packet's last bit has been taken.
- R5: The last bit of a finished packet can serve as the zero that comes before the next opening pair. If that last bit was a one, a zero must arrive before a new packet can open.
- R6: `dout` is never high in two consecutive cycles.
- R7: `rst` is synchronous and active high. While it is high, `dout` is 0. After it is released, the block is searching for an opening, has no open packet, and treats the preceding bit as a zero, whatever state it was in before.
- R8: With the defaults, the input stream 00010110101011001011100 (leftmost bit first) gives the output 00000000010000001000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one stream bit is taken per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| dout | output | 1 | Pulse: the packet ending this cycle holds exactly the target number of ones |

## Verification
The bench builds the block with its defaults: five-bit packets, a two-one opening and a target of three ones. This small setup makes it practical to drive every 11-bit input pattern from reset. That sweep covers every placement of an opening relative to reset, every way a packet can overlap a would-be opening, and every case where the last packet bit is reused as the leading zero. A pseudo-random long-stream pass, the fixed example stream and a reset applied in the middle of a packet complete the coverage.

// File: rtl/pktrx_pkg.sv
`timescale 1ns/1ps
package pktrx_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_RECV = 1'b1
   } rx_state_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/pktrx_hunt.sv
`timescale 1ns/1ps
// Opening detector: finds LEAD_ONES consecutive ones that follow a zero.
module pktrx_hunt #(
   parameter int LEAD_ONES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hunt_en,
   input  logic pkt_end,
   input  logic din,
   output logic start
);
   // blocked: no zero seen since the last one that could not open a packet
   logic blocked;

   generate
      if (LEAD_ONES == 1) begin : g_single
         assign start = hunt_en & din & ~blocked;

         always_ff @(posedge clk) begin
            if (rst) begin
               blocked <= 1'b0;
            end else if (pkt_end) begin
               blocked <= din;
            end else if (hunt_en) begin
               blocked <= din & blocked;
            end
         end
      end else begin : g_run
         localparam int RW = pktrx_pkg::cnt_width(LEAD_ONES - 1);
         logic [RW-1:0] run;

         assign start = hunt_en & din & ~blocked & (run == RW'(LEAD_ONES - 1));

         always_ff @(posedge clk) begin
            if (rst) begin
               blocked <= 1'b0;
               run     <= '0;
            end else if (pkt_end) begin
               blocked <= din;
               run     <= '0;
            end else if (hunt_en) begin
               if (!din) begin
                  blocked <= 1'b0;
                  run     <= '0;
               end else if (!blocked) begin
                  if (start) run <= '0;
                  else       run <= run + RW'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pktrx_tally.sv
`timescale 1ns/1ps
// Position and ones tally for the packet being received.
module pktrx_tally #(
   parameter int PKT_BITS  = 5,
   parameter int LEAD_ONES = 2,
   parameter int HIT_ONES  = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step,
   input  logic din,
   output logic last,
   output logic hit
);
   localparam int CW = pktrx_pkg::cnt_width(PKT_BITS);

   logic [CW-1:0] pos;
   logic [CW-1:0] ones;
   logic [CW-1:0] ones_nx;

   assign ones_nx = ones + {{(CW-1){1'b0}}, din};
   assign last    = (pos == CW'(PKT_BITS - 1));
   assign hit     = last & (ones_nx == CW'(HIT_ONES));

   always_ff @(posedge clk) begin
      if (rst) begin
         pos  <= '0;
         ones <= '0;
      end else if (load) begin
         pos  <= CW'(LEAD_ONES);
         ones <= CW'(LEAD_ONES);
      end else if (step) begin
         if (last) begin
            pos  <= '0;
            ones <= '0;
         end else begin
            pos  <= pos + CW'(1);
            ones <= ones_nx;
         end
      end
   end
endmodule

// File: rtl/pktrx_fsm.sv
`timescale 1ns/1ps
// Framing state: searching for an opening, or inside a packet.
module pktrx_fsm (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic last,
   output logic busy,
   output logic pkt_end
);
   import pktrx_pkg::*;

   rx_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         ST_HUNT: if (start) state_nx = ST_RECV;
         ST_RECV: if (last)  state_nx = ST_HUNT;
         default: state_nx = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_HUNT;
      else     state <= state_nx;
   end

   assign busy    = (state == ST_RECV);
   assign pkt_end = busy & last;
endmodule

// File: rtl/pktrx_ones_frame.sv
`timescale 1ns/1ps
module pktrx_ones_frame #(
   parameter int PKT_BITS  = 5,
   parameter int LEAD_ONES = 2,
   parameter int HIT_ONES  = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (LEAD_ONES < 1) begin : g_bad_lead
         $error("LEAD_ONES must be at least 1");
      end
      if (PKT_BITS <= LEAD_ONES) begin : g_bad_len
         $error("PKT_BITS must exceed LEAD_ONES");
      end
      if (HIT_ONES > PKT_BITS) begin : g_bad_hit
         $error("HIT_ONES cannot exceed PKT_BITS");
      end
   endgenerate

   logic start;
   logic busy;
   logic pkt_end;
   logic last;
   logic hit;

   pktrx_hunt #(.LEAD_ONES(LEAD_ONES)) u_hunt (
      .clk     (clk),
      .rst     (rst),
      .hunt_en (~busy),
      .pkt_end (pkt_end),
      .din     (din),
      .start   (start)
   );

   pktrx_tally #(
      .PKT_BITS  (PKT_BITS),
      .LEAD_ONES (LEAD_ONES),
      .HIT_ONES  (HIT_ONES)
   ) u_tally (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .step (busy),
      .din  (din),
      .last (last),
      .hit  (hit)
   );

   pktrx_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .last    (last),
      .busy    (busy),
      .pkt_end (pkt_end)
   );

   assign dout = busy & hit & ~rst;
endmodule

// File: rtl/pktrx_ones_frame_chk.sv
`timescale 1ns/1ps
module pktrx_ones_frame_chk #(
   parameter int PKT_BITS  = 5,
   parameter int LEAD_ONES = 2
) (
   input logic clk,
   input logic rst,
   input logic din,
   input logic dout,
   input logic busy
);
   localparam int BW   = pktrx_pkg::cnt_width(PKT_BITS);
   localparam int TAIL = PKT_BITS - LEAD_ONES;

   // consecutive busy cycles before the current one
   logic [BW-1:0] busy_cyc;

   always_ff @(posedge clk) begin
      if (rst || !busy)               busy_cyc <= '0;
      else if (busy_cyc != {BW{1'b1}}) busy_cyc <= busy_cyc + BW'(1);
   end

   // R1: a packet opens only on a cycle that took a one
   a_r1_open_on_one: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(din));

   // R2: never more than the packet's remaining bits spent inside it
   a_r2_packet_length: assert property (@(posedge clk) disable iff (rst)
      busy |-> (busy_cyc <= BW'(TAIL - 1)));

   // R3: a pulse only on the final bit of an open packet
   a_r3_pulse_on_last: assert property (@(posedge clk) disable iff (rst)
      dout |-> (busy && busy_cyc == BW'(TAIL - 1)));

   // R4: an open packet is not abandoned before its last bit
   a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy && busy_cyc < BW'(TAIL - 1)) |=> busy);

   // R6: single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      dout |=> !dout);

   // R7: reset clears the framing state
   a_r7_reset_idle: assert property (@(posedge clk)
      rst |=> !busy);

   // R7: output held low during reset
   a_r7_reset_quiet: assert property (@(posedge clk)
      rst |-> !dout);
endmodule

bind pktrx_ones_frame pktrx_ones_frame_chk #(
   .PKT_BITS  (PKT_BITS),
   .LEAD_ONES (LEAD_ONES)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .din  (din),
   .dout (dout),
   .busy (busy)
);

// File: tb/sim_pktrx_ones_frame.sv
`timescale 1ns/1ps
module sim_pktrx_ones_frame;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic dout;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic seq  [0:63];
   logic expv [0:63];
   int   len;
   logic prev_dout;

   always #10 clk = ~clk;   // 50 MHz

   pktrx_ones_frame u0 (
      .clk  (clk),
      .rst  (rst),
      .din  (din),
      .dout (dout)
   );

   // Expected outputs from the requirements (defaults: 5 bits, 2-one opening, 3 ones)
   task automatic build_expect();
      int free_at = 0;   // earliest index a packet's first bit may occupy
      for (int i = 0; i < len; i++) expv[i] = 1'b0;
      for (int j = 1; j < len; j++) begin
         logic zero_before;
         zero_before = (j < 2) ? 1'b1 : !seq[j-2];
         if ((j - 1) >= free_at && seq[j-1] && seq[j] && zero_before) begin
            int ones = 0;
            for (int k = j - 1; k <= j + 3; k++)
               if (k < len && seq[k]) ones++;
            if (j + 3 < len) expv[j+3] = (ones == 3);
            free_at = j + 4;
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      din = 1'b1;
      #5;
      n_cmp++;
      if (dout !== 1'b0) begin
         n_bad++;
         $display("FAIL R7 dout during reset: actual %b expected 0", dout);
      end
      @(negedge clk);
      rst = 1'b0;
      din = 1'b0;
      prev_dout = 1'b0;
   endtask

   // feeds seq[0..len-1] after the current state; tag names the requirement group
   task automatic feed(input string tag);
      for (int i = 0; i < len; i++) begin
         if (i > 0) @(negedge clk);
         din = seq[i];
         #5;
         n_cmp++;
         if (dout !== expv[i]) begin
            n_bad++;
            $display("FAIL %s bit %0d: actual %b expected %b", tag, i, dout, expv[i]);
         end
         if (dout === 1'b1 && prev_dout === 1'b1) begin
            n_bad++;
            $display("FAIL R6 two-cycle pulse at bit %0d: actual 11 expected 10", i);
         end
         prev_dout = dout;
      end
   endtask

   initial begin
      logic [22:0] ex_in  = 23'b00010110101011001011100;
      logic [22:0] ex_out = 23'b00000000010000001000001;
      logic [15:0] lfsr = 16'hACE1;

      repeat (3) @(negedge clk);

      // R1 R2 R3 R4 R5: all 11-bit patterns from reset
      len = 11;
      for (int p = 0; p < 2048; p++) begin
         for (int i = 0; i < 11; i++) seq[i] = p[10-i];
         build_expect();
         do_reset();
         feed("R1 R2 R3 R4 R5 sweep");
      end

      // R8: fixed example stream against its literal output
      len = 23;
      for (int i = 0; i < 23; i++) begin
         seq[i]  = ex_in[22-i];
         expv[i] = ex_out[22-i];
      end
      do_reset();
      feed("R8 example");

      // R7: reset in the middle of a packet, then 1,1,0,0,1 opens at once (3 ones)
      len = 3;
      seq[0] = 0; seq[1] = 1; seq[2] = 1;
      build_expect();
      do_reset();
      feed("R7 pre-reset");
      len = 5;
      seq[0] = 1; seq[1] = 1; seq[2] = 0; seq[3] = 0; seq[4] = 1;
      for (int i = 0; i < 5; i++) expv[i] = (i == 4);
      do_reset();
      feed("R7 after mid-packet reset");

      // R4 R5: long pseudo-random streams
      len = 64;
      for (int r = 0; r < 40; r++) begin
         for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            seq[i] = lfsr[0] | (lfsr[3] & (r[0]));
         end
         build_expect();
         do_reset();
         feed("R4 R5 stream");
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule